// File: doc/BRIEF.md
# Host-Clocked Double-Edge Nibble Stream Port

This block sends 48-bit IQ receive samples to a host processor over four data lines. The host has no fast interface for this. It reads the lines through general-purpose I/O and supplies the only clock of the link. Samples enter through a write port and wait in a small FIFO. The serializer then puts them on the data lines four bits at a time, most significant nibble first. Every rising edge and every falling edge of the host clock moves the output to the next nibble, so one host clock period carries a full byte.

The host follows a simple routine. It polls the ready line, or takes an interrupt from it. It reads the nibble already on the lines, toggles its clock, and reads again. Twelve reads give one sample. Samples from several receive channels are written in channel order, and they leave in that same order.

Two sticky status outputs report faults. One flags a host read that found no data. The other flags a sample that was lost because the FIFO was full. If the host leaves its clock low and idle for a programmable time, the port rewinds to the first nibble of the current word. This lets the host resynchronise to a word boundary.

Top module: `rx_nibble_port`

## Requirements
- R1: After reset, `host_nib` is 0, and `host_rdy`, `underrun` and `overflow` are all 0.
- R2: When a word reaches the serializer, its bits 47:44 appear on `host_nib` before any host clock edge.
- R3: Each host clock edge, rising or falling, moves `host_nib` to the next nibble of the current word. Nibble i carries bits 47-4i down to 44-4i, for i from 0 to 11.
- R4: Words leave in the order they were written. The twelfth edge of a word brings the next word's bits 47:44 onto the lines, without a gap.
- R5: `host_rdy` rises when the number of complete unread samples reaches `rdy_level` and is not zero. A sample counts as complete while it waits in the FIFO, or while it is loaded with none of its edges taken yet.
- R6: `host_rdy` stays high until no complete unread sample remains. It falls once the first edge of the last word has been taken.
- R7: A host clock edge that arrives with no word loaded leaves `host_nib` at 0 and sets `underrun`. `underrun` stays set until reset.
- R8: A write that arrives while the FIFO holds DEPTH words is dropped and never appears on `host_nib`. It sets `overflow`, which stays set until reset.
- R9: If the synchronised host clock stays low with no edge for TIMEOUT system cycles, the port returns to nibble 0 of the word it holds. A clock held high never causes this rewind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample write strobe |
| smp_data | input | 48 | IQ sample to enqueue |
| rdy_level | input | $clog2(DEPTH+2) | Number of complete samples needed to raise the ready flag |
| host_clk | input | 1 | Transfer clock from the host (asynchronous) |
| host_nib | output | 4 | Nibble presented to the host |
| host_rdy | output | 1 | Samples-waiting flag for polling or interrupt |
| underrun | output | 1 | Sticky flag: the host read with no data |
| overflow | output | 1 | Sticky flag: a sample was dropped because the FIFO was full |

## Verification
The bench builds the port with DEPTH 4, TIMEOUT 32 and full 48-bit words. With a FIFO that shallow, every ready threshold from 1 to 4 can be swept against every fill level from 1 to 4 words. The sweep reaches both edges of the ready flag and runs through every nibble position of every word. Overflow happens after only six writes. The short timeout lets the bench test the rewind, and check that a high clock does not cause it, in a few dozen cycles.

// File: rtl/rxn_pkg.sv
// Package: constants shared by the nibble stream port.
// Assumes the link width is fixed at four data lines.
package rxn_pkg;
    parameter int NIB_W = 4;

    // Number of nibbles needed to carry a word of the given width.
    function automatic int nibs_per_word(input int word_w);
        return word_w / NIB_W;
    endfunction
endpackage

// File: rtl/rxn_hclk_sync.sv
// Host clock synchronizer and edge detector.
// Brings the asynchronous host clock into the system domain through two
// flops, then flags any change of level (either edge) with a third flop.
// Assumes the host clock is far slower than the system clock.
module rxn_hclk_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic host_clk,
    output logic hsync,
    output logic hedge
);
    logic s1, s2, s3;

    // Two-stage synchronizer followed by a delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= host_clk;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign hsync = s2;
    assign hedge = s2 ^ s3;
endmodule

// File: rtl/rxn_sample_fifo.sv
// Sample FIFO with a first-word-fall-through read port.
// Drops any write that arrives while full and latches a sticky overflow flag.
// Assumes DEPTH is a power of two.
module rxn_sample_fifo #(
    parameter int WORD_W = 48,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              empty,
    output logic [CNT_W-1:0]  count,
    output logic              overflow
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic              full, push, pop;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign push  = wr_en && !full;
    assign pop   = rd_en && !empty;

    // Storage array; it needs no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_data;
    end

    // Pointers, occupancy and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr_en && full) overflow <= 1'b1;
        end
    end

    assign rd_data = mem[rptr];
endmodule

// File: rtl/rxn_serializer.sv
// Word-to-nibble serializer driven by host clock edges.
// Loads a word as soon as one is available and nothing is loaded, and shows
// its top nibble at once. Each edge then advances one nibble. An edge with
// nothing loaded sets the sticky underrun flag. A long low idle rewinds to
// nibble 0. Assumes hedge is a single-cycle pulse.
module rxn_serializer #(
    parameter int WORD_W  = 48,
    parameter int TIMEOUT = 4096,
    localparam int NIB_W  = rxn_pkg::NIB_W,
    localparam int NIBS   = rxn_pkg::nibs_per_word(WORD_W),
    localparam int IDX_W  = $clog2(NIBS),
    localparam int TO_W   = $clog2(TIMEOUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              hedge,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_data,
    output logic              pop,
    output logic              rewind,
    output logic              fresh,
    output logic [NIB_W-1:0]  nib,
    output logic              underrun
);
    logic [WORD_W-1:0] word;
    logic [IDX_W-1:0]  idx;
    logic              loaded;
    logic [TO_W-1:0]   idle;
    logic              last;
    logic [WORD_W-1:0] shifted;

    assign last   = (idx == IDX_W'(NIBS - 1));
    assign pop    = !fifo_empty && (!loaded || (hedge && last));
    assign rewind = (idle == TO_W'(TIMEOUT - 1)) && !hsync && !hedge;
    assign fresh  = loaded && (idx == '0);

    // Word register, nibble index and underrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word     <= '0;
            idx      <= '0;
            loaded   <= 1'b0;
            underrun <= 1'b0;
        end else if (pop) begin
            word   <= fifo_data;
            idx    <= '0;
            loaded <= 1'b1;
        end else if (hedge) begin
            if (!loaded)   underrun <= 1'b1;
            else if (last) loaded   <= 1'b0;
            else           idx      <= idx + 1'b1;
        end else if (rewind) begin
            idx <= '0;
        end
    end

    // Idle counter: counts system cycles while the host clock stays low.
    always_ff @(posedge clk) begin
        if (!rst_n || hedge || hsync) idle <= '0;
        else if (idle != TO_W'(TIMEOUT)) idle <= idle + 1'b1;
    end

    // Nibble select: most significant nibble first.
    always_comb begin
        shifted = word << (idx * NIB_W);
        nib     = loaded ? shifted[WORD_W-1 -: NIB_W] : '0;
    end
endmodule

// File: rtl/rx_nibble_port.sv
// Top level of the host-clocked double-edge nibble stream port.
// Buffers samples, serializes them on both host clock edges, and drives a
// ready flag with hysteresis. The flag is set at the threshold and cleared
// when no complete sample is left. Assumes DEPTH is a power of two and
// WORD_W is a multiple of four.
module rx_nibble_port #(
    parameter int WORD_W  = 48,
    parameter int DEPTH   = 16,
    parameter int TIMEOUT = 4096,
    localparam int NIB_W  = rxn_pkg::NIB_W,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int AV_W   = $clog2(DEPTH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_data,
    input  logic [AV_W-1:0]   rdy_level,
    input  logic              host_clk,
    output logic [NIB_W-1:0]  host_nib,
    output logic              host_rdy,
    output logic              underrun,
    output logic              overflow
);
    logic              hsync, hedge, pop, rewind, fresh, fifo_empty;
    logic [WORD_W-1:0] fifo_data;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [AV_W-1:0]   avail;

    rxn_hclk_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_clk (host_clk),
        .hsync    (hsync),
        .hedge    (hedge)
    );

    rxn_sample_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (smp_valid),
        .wr_data  (smp_data),
        .rd_en    (pop),
        .rd_data  (fifo_data),
        .empty    (fifo_empty),
        .count    (fifo_cnt),
        .overflow (overflow)
    );

    rxn_serializer #(.WORD_W(WORD_W), .TIMEOUT(TIMEOUT)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync      (hsync),
        .hedge      (hedge),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .pop        (pop),
        .rewind     (rewind),
        .fresh      (fresh),
        .nib        (host_nib),
        .underrun   (underrun)
    );

    // Complete samples: the FIFO contents plus a loaded word not yet started.
    assign avail = AV_W'(fifo_cnt) + AV_W'(fresh);

    // Ready flag: set at the threshold, held until nothing complete remains.
    always_ff @(posedge clk) begin
        if (!rst_n)        host_rdy <= 1'b0;
        else if (host_rdy) host_rdy <= (avail != '0);
        else               host_rdy <= (avail >= rdy_level) && (avail != '0);
    end
endmodule

// File: rtl/rx_nibble_port_chk.sv
// Assertion checker for rx_nibble_port, attached through bind.
// Observes the top-level ports and the signals passed between submodules.
module rx_nibble_port_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5,
    parameter int AV_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic             hedge,
    input logic             pop,
    input logic             rewind,
    input logic [3:0]       host_nib,
    input logic             host_rdy,
    input logic             underrun,
    input logic             overflow,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic [AV_W-1:0]  avail
);
    logic past_ok;

    // Marks the cycles after the first clocked cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_NIB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !hedge && !pop && !rewind |=> $stable(host_nib)); // R3
    AST_RDY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $rose(host_rdy) |-> $past(avail) != '0); // R5
    AST_RDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy && avail == '0 |=> !host_rdy); // R6
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun); // R7
    AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $rose(underrun) |-> $past(hedge)); // R7
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R8
    AST_OVERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $rose(overflow) |-> $past(smp_valid) && $past(fifo_cnt) == CNT_W'(DEPTH)); // R8
    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH)); // R8
endmodule

bind rx_nibble_port rx_nibble_port_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AV_W(AV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .hedge     (hedge),
    .pop       (pop),
    .rewind    (rewind),
    .host_nib  (host_nib),
    .host_rdy  (host_rdy),
    .underrun  (underrun),
    .overflow  (overflow),
    .fifo_cnt  (fifo_cnt),
    .avail     (avail)
);

// File: tb/rx_nibble_port_tb.sv
// Bench for rx_nibble_port: sweeps thresholds and fill levels, then covers
// underrun, overflow and the idle rewind.
module rx_nibble_port_tb;
    localparam int WORD_W  = 48;
    localparam int DEPTH   = 4;
    localparam int TIMEOUT = 32;
    localparam int AV_W    = $clog2(DEPTH + 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [WORD_W-1:0] smp_data = '0;
    logic [AV_W-1:0]   rdy_level = '0;
    logic              host_clk = 1'b0;
    logic [3:0]        host_nib;
    logic              host_rdy, underrun, overflow;

    int tests = 0;
    int fails = 0;
    logic rdy_m;

    always #5 clk = ~clk;

    rx_nibble_port #(.WORD_W(WORD_W), .DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .rdy_level(rdy_level), .host_clk(host_clk), .host_nib(host_nib),
        .host_rdy(host_rdy), .underrun(underrun), .overflow(overflow)
    );

    function automatic logic [WORD_W-1:0] word_of(input int k);
        return 48'h9A3C_5E71_B2D4 + WORD_W'(k) * 48'h1357_9BDF_0246;
    endfunction

    function automatic logic [3:0] nib_of(input logic [WORD_W-1:0] w, input int i);
        logic [WORD_W-1:0] t;
        t = w >> (WORD_W - 4 - 4 * i);
        return t[3:0];
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input int th);
        @(negedge clk);
        host_clk  = 1'b0;
        smp_valid = 1'b0;
        rst_n     = 1'b0;
        rdy_level = AV_W'(th);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rdy_m = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input int k);
        smp_valid = 1'b1;
        smp_data  = word_of(k);
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic edge_step();
        host_clk = ~host_clk;
        repeat (6) @(negedge clk);
    endtask

    // Ready model derived from R5/R6: rise at threshold, fall at zero.
    task automatic upd_rdy(input int a, input int th);
        if (rdy_m) rdy_m = (a != 0);
        else       rdy_m = (a >= th) && (a != 0);
    endtask

    // Reads one whole word, checking each nibble (R3, R4) and the ready flag.
    task automatic read_word(input int k, input int left, input int th, input logic chk_rdy);
        for (int i = 0; i < 12; i++) begin
            check(host_nib == nib_of(word_of(k), i), "R3/R4 nibble", host_nib, nib_of(word_of(k), i));
            if (chk_rdy && i == 0)
                check(host_rdy == rdy_m, "R5 ready before word", host_rdy, rdy_m);
            edge_step();
            if (chk_rdy && i == 0) begin
                upd_rdy(left - 1, th);
                check(host_rdy == rdy_m, "R6 ready after first edge", host_rdy, rdy_m);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(1);
        check(host_nib == 4'h0, "R1 nib", host_nib, 0);
        check(host_rdy == 1'b0, "R1 rdy", host_rdy, 0);
        check(underrun == 1'b0, "R1 underrun", underrun, 0);
        check(overflow == 1'b0, "R1 overflow", overflow, 0);

        // Sweep: every threshold against every fill level.
        for (int th = 1; th <= DEPTH; th++) begin
            for (int n = 1; n <= DEPTH; n++) begin
                do_reset(th);
                for (int k = 0; k < n; k++) begin
                    wr(k);
                    upd_rdy(k + 1, th);
                    check(host_rdy == rdy_m, "R5 ready on fill", host_rdy, rdy_m);
                    if (k == 0)
                        check(host_nib == nib_of(word_of(0), 0), "R2 first nibble early", host_nib, nib_of(word_of(0), 0));
                end
                for (int k = 0; k < n; k++) read_word(k, n - k, th, 1'b1);
                check(host_rdy == 1'b0, "R6 ready after drain", host_rdy, 0);
                check(underrun == 1'b0, "R7 no underrun yet", underrun, 0);
                edge_step();
                check(host_nib == 4'h0, "R7 zero on underrun", host_nib, 0);
                check(underrun == 1'b1, "R7 underrun set", underrun, 1);
                edge_step();
                check(underrun == 1'b1, "R7 underrun sticky", underrun, 1);
            end
        end

        // R8: overflow, five words fit (FIFO plus serializer), the sixth drops.
        do_reset(1);
        for (int k = 0; k < DEPTH + 1; k++) wr(k);
        check(overflow == 1'b0, "R8 no overflow at capacity", overflow, 0);
        wr(DEPTH + 1);
        check(overflow == 1'b1, "R8 overflow set", overflow, 1);
        for (int k = 0; k < DEPTH + 1; k++) read_word(k, 0, 1, 1'b0);
        check(host_nib == 4'h0, "R8 dropped word absent", host_nib, 0);
        edge_step();
        check(host_nib == 4'h0, "R8 dropped word absent after edge", host_nib, 0);
        check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);

        // R9: idle rewind only while the host clock is low.
        do_reset(1);
        wr(7);
        wr(8);
        for (int i = 0; i < 3; i++) edge_step();
        repeat (TIMEOUT + 10) @(negedge clk);
        check(host_nib == nib_of(word_of(7), 3), "R9 no rewind while high", host_nib, nib_of(word_of(7), 3));
        edge_step();
        check(host_nib == nib_of(word_of(7), 4), "R9 before timeout", host_nib, nib_of(word_of(7), 4));
        repeat (TIMEOUT + 10) @(negedge clk);
        check(host_nib == nib_of(word_of(7), 0), "R9 rewind to nibble 0", host_nib, nib_of(word_of(7), 0));
        read_word(7, 0, 1, 1'b0);
        read_word(8, 0, 1, 1'b0);
        check(underrun == 1'b0, "R9 no underrun after rewind", underrun, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule